// File: doc/BRIEF.md
# Dual-Convention Stack Push/Pop Sequencer

This block keeps a stack pointer and carries out one push or pop at a time, either one byte or one two-byte word, over a byte-wide synchronous memory port. A caller offers a request on a valid/ready handshake. The request gives the direction (push or pop), the size (byte or word) and, for a push, the data. The block then runs the byte cycles on the memory port, updates the stack pointer once, and raises a one-cycle done pulse. For a pop, the read value comes with that pulse.

A mode pin picks how the pointer is read, and it is sampled when a request is accepted. In next-free mode the pointer addresses the empty slot just below the stack. In top-item mode it addresses the most recently stored byte. Words are kept with the more significant byte at the lower address.

Back-pressure rules for the request side: a request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the edge after acceptance until the operation has finished. A request offered while `req_ready` is low has no effect. The done pulse cannot be stalled, so the consumer must take `rsp_rdata` in the cycle where `rsp_valid` is high. The memory returns read data one cycle after the access cycle. A separate load port sets the pointer directly at start-up.

Top module: `stk_engine`

## Requirements
- R1: After reset, `sp_out` is 0x0000, `req_ready` is 1, and `rsp_valid` and `mem_en` are 0.
- R2: In next-free mode (`sp_conv`=0), a byte push writes `req_wdata[7:0]` at address SP, and SP becomes SP-1.
- R3: In next-free mode, a word push writes the word at SP-1 and SP, and SP becomes SP-2.
- R4: In next-free mode, a byte pop reads address SP+1 and SP becomes SP+1. A word pop reads SP+1 and SP+2, and SP becomes SP+2.
- R5: In top-item mode (`sp_conv`=1), a byte push writes at SP-1 and a word push writes at SP-2 and SP-1. SP ends at the lowest address written.
- R6: In top-item mode, a pop reads starting at SP, and SP then grows by 1 (byte) or 2 (word).
- R7: A word is big-endian. A push writes `req_wdata[15:8]` at the lower address and then `req_wdata[7:0]` at the next address. A pop returns the lower-address byte in `rsp_rdata[15:8]`. A byte pop returns the byte in `rsp_rdata[7:0]` with the upper byte 0.
- R8: `rsp_valid` is high for exactly one cycle: 2 clock edges after the accepting edge for a byte operation and 3 for a word operation. SP changes only on the edge that raises `rsp_valid`, or on a load.
- R9: While an operation is in progress, `req_ready` is 0, and a request offered then starts nothing. It makes no memory access and does not change SP.
- R10: When `sp_load` is high at an edge, SP takes `sp_load_val`. This load wins over a completion update on the same edge.
- R11: All pointer and address arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sp_conv | input | 1 | 0 = next-free, 1 = top-item; sampled at acceptance |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_pop | input | 1 | 1 = pop, 0 = push |
| req_wide | input | 1 | 1 = word, 0 = byte |
| req_wdata | input | 16 | Push data (byte pushes use bits 7:0) |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 16 | Pop result, valid with `rsp_valid` |
| sp_load | input | 1 | Load the stack pointer |
| sp_load_val | input | 16 | Value to load |
| sp_out | output | 16 | Current stack pointer |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after the access |

## Verification
The first memory access comes in the cycle right after the accepting edge, and the second byte of a word follows in the next cycle. The done pulse and the new SP appear together 2 edges after acceptance for a byte and 3 for a word. The bench drives every input on the falling edge. It counts rising edges from acceptance, reads the outputs only at falling edges, and compares the count with these figures. It also reads the memory access log in the cycles where those accesses are due.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BYTE0 = 2'd1,
    ST_BYTE1 = 2'd2,
    ST_FIN   = 2'd3
  } stk_state_e;

  typedef enum logic {
    SP_NEXT_FREE = 1'b0,
    SP_TOP_ITEM  = 1'b1
  } sp_conv_e;
endpackage

// File: rtl/stk_addr_plan.sv
module stk_addr_plan
  import stk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] sp,
  input  sp_conv_e      conv,
  input  logic          pop,
  input  logic          wide,
  output logic [AW-1:0] first_addr,
  output logic [AW-1:0] next_sp
);
  logic [AW-1:0] step;
  logic [AW-1:0] bias;

  always_comb begin
    step = wide ? AW'(2) : AW'(1);
    bias = (conv == SP_NEXT_FREE) ? AW'(1) : AW'(0);
    if (pop) begin
      first_addr = sp + bias;
      next_sp    = sp + step;
    end else begin
      first_addr = sp - step + bias;
      next_sp    = sp - step;
    end
  end
endmodule

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
  parameter int          AW     = 16,
  parameter logic [AW-1:0] SP_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          upd,
  input  logic [AW-1:0] upd_val,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= SP_RST;
    else if (load) sp <= load_val;
    else if (upd)  sp <= upd_val;
  end
endmodule

// File: rtl/stk_byte_seq.sv
module stk_byte_seq
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  localparam int DW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          pop,
  input  logic          wide,
  input  logic [AW-1:0] first_addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          finish,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  stk_state_e    state_q, state_d;
  logic          pop_q, wide_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [BW-1:0] hi_q;

  always_comb begin
    state_d   = state_q;
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    mem_wdata = wdata_q[BW-1:0];
    finish    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_BYTE0;
      ST_BYTE0: begin
        mem_en = 1'b1;
        mem_we = !pop_q;
        if (wide_q) mem_wdata = wdata_q[DW-1:BW];
        state_d = wide_q ? ST_BYTE1 : ST_FIN;
      end
      ST_BYTE1: begin
        mem_en   = 1'b1;
        mem_we   = !pop_q;
        mem_addr = addr_q + AW'(1);
        state_d  = ST_FIN;
      end
      ST_FIN: begin
        finish  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pop_q     <= 1'b0;
      wide_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      hi_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= (state_q == ST_FIN);
      if (state_q == ST_IDLE && start) begin
        pop_q   <= pop;
        wide_q  <= wide;
        addr_q  <= first_addr;
        wdata_q <= wdata;
      end
      if (state_q == ST_BYTE1) hi_q <= mem_rdata;
      if (state_q == ST_FIN) begin
        if (!pop_q)      rsp_rdata <= '0;
        else if (wide_q) rsp_rdata <= {hi_q, mem_rdata};
        else             rsp_rdata <= {{BW{1'b0}}, mem_rdata};
      end
    end
  end
endmodule

// File: rtl/stk_engine.sv
module stk_engine
  import stk_pkg::*;
#(
  parameter int            AW     = 16,
  parameter int            BW     = 8,
  parameter logic [AW-1:0] SP_RST = '0,
  localparam int           DW     = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_conv,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_pop,
  input  logic          req_wide,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          sp_load,
  input  logic [AW-1:0] sp_load_val,
  output logic [AW-1:0] sp_out,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_wdata,
  input  logic [BW-1:0] mem_rdata
);
  logic          busy, finish, start;
  logic [AW-1:0] plan_first, plan_next, next_sp_q;

  assign req_ready = !busy;
  assign start     = req_valid && req_ready;

  stk_addr_plan #(.AW(AW)) u_plan (
    .sp(sp_out), .conv(sp_conv_e'(sp_conv)), .pop(req_pop), .wide(req_wide),
    .first_addr(plan_first), .next_sp(plan_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     next_sp_q <= SP_RST;
    else if (start) next_sp_q <= plan_next;
  end

  stk_byte_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pop(req_pop), .wide(req_wide),
    .first_addr(plan_first), .wdata(req_wdata), .busy(busy), .finish(finish),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  stk_sp_reg #(.AW(AW), .SP_RST(SP_RST)) u_sp (
    .clk(clk), .rst_n(rst_n), .load(sp_load), .load_val(sp_load_val),
    .upd(finish), .upd_val(next_sp_q), .sp(sp_out)
  );
endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          sp_load,
  input logic [AW-1:0] sp_load_val,
  input logic [AW-1:0] sp_out,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_mem_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_sp_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sp_load |=> (rsp_valid || $stable(sp_out)));

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sp_load |=> (sp_out == $past(sp_load_val)));

  p_we_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  p_word_ascends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && $past(mem_en)) |-> (mem_addr == AW'($past(mem_addr) + AW'(1))));
endmodule

bind stk_engine stk_engine_chk #(.AW(AW)) u_chk (.*);

// File: tb/stk_engine_tb.sv
module stk_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        lu;
    logic        pop;
    logic        wide;
    logic [15:0] sp0;
    logic [15:0] wd;
    logic [15:0] esp;
    logic [15:0] ea0;
    logic [15:0] erd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'h1040, 16'h00A7, 16'h103F, 16'h1040, 16'h0000},
    '{1'b0, 1'b0, 1'b1, 16'h2080, 16'hBEEF, 16'h207E, 16'h207F, 16'h0000},
    '{1'b0, 1'b1, 1'b0, 16'h3010, 16'h0000, 16'h3011, 16'h3011, 16'h00EE},
    '{1'b0, 1'b1, 1'b1, 16'h4020, 16'h0000, 16'h4022, 16'h4021, 16'hDEDD},
    '{1'b1, 1'b0, 1'b0, 16'h5050, 16'h0033, 16'h504F, 16'h504F, 16'h0000},
    '{1'b1, 1'b0, 1'b1, 16'h6060, 16'h1234, 16'h605E, 16'h605E, 16'h0000},
    '{1'b1, 1'b1, 1'b0, 16'h7030, 16'h0000, 16'h7031, 16'h7030, 16'h00CF},
    '{1'b1, 1'b1, 1'b1, 16'h8032, 16'h0000, 16'h8034, 16'h8032, 16'hCDCC},
    '{1'b0, 1'b0, 1'b1, 16'h0000, 16'hA55A, 16'hFFFE, 16'hFFFF, 16'h0000},
    '{1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 16'h0001, 16'hFFFF, 16'hA55A},
    '{1'b0, 1'b1, 1'b0, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 16'h005A},
    '{1'b1, 1'b0, 1'b0, 16'h0000, 16'h0077, 16'hFFFF, 16'hFFFF, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sp_conv = 1'b0, req_valid = 1'b0, req_pop = 1'b0, req_wide = 1'b0;
  logic [15:0] req_wdata = '0, sp_load_val = '0;
  logic        sp_load = 1'b0;
  logic        req_ready, rsp_valid, mem_en, mem_we;
  logic [15:0] rsp_rdata, sp_out, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  logic [7:0]  mem [256];
  logic [15:0] acc_addr [256];
  logic        acc_we   [256];
  logic [7:0]  acc_wd   [256];
  int          acc_n = 0;

  stk_engine dut_i (
    .clk(clk), .rst_n(rst_n), .sp_conv(sp_conv), .req_valid(req_valid),
    .req_ready(req_ready), .req_pop(req_pop), .req_wide(req_wide),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sp_load(sp_load), .sp_load_val(sp_load_val), .sp_out(sp_out),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Byte memory with one cycle of read latency, plus an access log.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= ~8'(i);
      mem_rdata <= '0;
    end else if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
      acc_addr[acc_n[7:0]] <= mem_addr;
      acc_we[acc_n[7:0]]   <= mem_we;
      acc_wd[acc_n[7:0]]   <= mem_wdata;
      acc_n <= acc_n + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic load_sp(input logic [15:0] v);
    sp_load = 1'b1;
    sp_load_val = v;
    @(posedge clk);
    @(negedge clk);
    sp_load = 1'b0;
  endtask

  // Issue one request at a falling edge; returns edges until done.
  task automatic run_op(input logic lu, input logic pop, input logic wide,
                        input logic [15:0] wd, output int lat,
                        output logic [15:0] rd, output int base);
    sp_conv = lu; req_pop = pop; req_wide = wide; req_wdata = wd;
    req_valid = 1'b1;
    base = acc_n;
    lat = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat++;
    end while (!rsp_valid && lat < 10);
    rd = rsp_rdata;
  endtask

  function automatic string tag_of(int idx, logic lu, logic pop, logic wide);
    if (idx >= 8) return "R11";
    if (!lu && !pop) return wide ? "R3" : "R2";
    if (!lu && pop)  return "R4";
    if (lu && !pop)  return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    int lat, base;
    logic [15:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", 32'(sp_out), 32'h0000);
    chk("R1 ready", 32'(req_ready), 32'h1);
    chk("R1 done", 32'(rsp_valid), 32'h0);
    chk("R1 mem_en", 32'(mem_en), 32'h0);

    for (int v = 0; v < NV; v++) begin
      vec_t x;
      string t;
      x = VECS[v];
      t = tag_of(v, x.lu, x.pop, x.wide);
      load_sp(x.sp0);
      run_op(x.lu, x.pop, x.wide, x.wd, lat, rd, base);
      chk({t, " sp"}, 32'(sp_out), 32'(x.esp));
      chk("R8 latency", 32'(lat), x.wide ? 32'd4 : 32'd3);
      chk({t, " count"}, 32'(acc_n - base), x.wide ? 32'd2 : 32'd1);
      chk({t, " addr0"}, 32'(acc_addr[base[7:0]]), 32'(x.ea0));
      chk({t, " we"}, 32'(acc_we[base[7:0]]), 32'(!x.pop));
      if (x.wide)
        chk("R7 addr1", 32'(acc_addr[8'(base + 1)]), 32'(16'(x.ea0 + 16'd1)));
      if (!x.pop) begin
        chk("R7 byte0", 32'(acc_wd[base[7:0]]), x.wide ? 32'(x.wd[15:8]) : 32'(x.wd[7:0]));
        if (x.wide) chk("R7 byte1", 32'(acc_wd[8'(base + 1)]), 32'(x.wd[7:0]));
      end else begin
        chk("R7 rdata", 32'(rd), 32'(x.erd));
      end
      @(negedge clk);
      chk("R8 pulse", 32'(rsp_valid), 32'h0);
    end

    // R9: a request offered while busy is ignored
    load_sp(16'h0900);
    sp_conv = 1'b0; req_pop = 1'b0; req_wide = 1'b0; req_wdata = 16'h0011;
    req_valid = 1'b1;
    base = acc_n;
    @(posedge clk);
    @(negedge clk);
    chk("R9 ready low", 32'(req_ready), 32'h0);
    req_pop = 1'b1; req_wide = 1'b1;
    lat = 1;
    while (!rsp_valid && lat < 10) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    chk("R9 sp", 32'(sp_out), 32'h08FF);
    repeat (3) @(negedge clk);
    chk("R9 sp later", 32'(sp_out), 32'h08FF);
    chk("R9 accesses", 32'(acc_n - base), 32'd1);

    // R10: load wins over completion update on the same edge
    load_sp(16'h0A00);
    sp_conv = 1'b0; req_pop = 1'b1; req_wide = 1'b0;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    sp_load = 1'b1;
    sp_load_val = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    sp_load = 1'b0;
    chk("R10 done", 32'(rsp_valid), 32'h1);
    chk("R10 sp", 32'(sp_out), 32'h1234);
    @(negedge clk);
    chk("R10 sp hold", 32'(sp_out), 32'h1234);

    finish_run();
  end
endmodule